// File: doc/BRIEF.md
# Common Interrupt Distributor

This block takes a set of shared, level-sensitive interrupt inputs and steers each one to the cores of a cluster. Every line has its own destination core mask, a distribution selector and a mask bit. In fixed routing the line goes to one core only. In balanced routing, successive assertions rotate among the cores named in its destination mask. Nothing reaches any core until a global enable command has been written.

Configuration arrives one command per cycle on a write port. A command carries an opcode, a line number and a data word. Each core has one output wire per shared line, and can acknowledge any line on a per-core, per-line acknowledge wire. Outputs are registered and follow the level of the input one clock later, as long as the line is allowed to forward.

Top module: `irq_distributor`

## Requirements
- R1: After reset every output is 0, every line is masked, every destination mask is zero and the global enable is off.
- R2: The opcode 3'd1 turns the global enable on. Until that command has been accepted, every output stays 0 whatever the inputs and the per-line settings are.
- R3: Opcode 3'd4 writes the mask bit of line `cmdIrq` from `cmdData[0]`, with 1 meaning masked and 0 meaning unmasked. A masked line drives 0 to every core.
- R4: For a given line, at most one core's output is 1 at any time. The output for core c and line i is `irqOut[c*NUM_IRQ+i]`, and the acknowledge from core c for line i is `coreAck[c*NUM_IRQ+i]`.
- R5: Opcode 3'd3 writes the mode word of a line. When mode bits [1:0] are not 00 the line is in fixed routing, and it delivers to the lowest-numbered core whose bit is set in the destination mask.
- R6: When mode bits [1:0] are 00 the line is in balanced routing. After a destination write it delivers to the lowest set core. An acknowledge from the core currently chosen moves delivery to the next set core above it, wrapping from the top back to the lowest.
- R7: In balanced routing the choice moves at most once per assertion. If no acknowledge from the chosen core has moved it while the input was high, the choice moves when the input deasserts. A second acknowledge during the same assertion has no effect.
- R8: Opcode 3'd2 writes the destination mask of a line from `cmdData[NUM_CORE-1:0]`. It restarts the balanced-routing choice at the lowest set bit of the new mask.
- R9: A line whose destination mask is all zero drives 0 to every core.
- R10: Only mode bits [1:0] have any effect. Bit 4, the trigger-type flag, and every other bit are ignored, because all lines behave as level inputs.
- R11: A forwarding line's output equals the input level sampled on the previous clock edge. A configuration command takes effect on the output one cycle after it is accepted.
- R12: Acknowledges from cores that are not currently chosen, and any acknowledge on a line in fixed routing, leave the routing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | Opcode: 1 enable, 2 destination, 3 mode, 4 mask; other values do nothing |
| cmdIrq | input | IRQ_IDX_W | Line addressed by the command |
| cmdData | input | DATA_W | Command data word |
| irqIn | input | NUM_IRQ | Shared level interrupt inputs |
| coreAck | input | NUM_CORE*NUM_IRQ | Per-core, per-line acknowledge pulses |
| irqOut | output | NUM_CORE*NUM_IRQ | Per-core, per-line interrupt outputs |

## Verification
The checker relies on commands being single-cycle strobes on `cmdValid`, so that a mask-set command is seen exactly once. It also relies on interrupt inputs being plain levels that change only between clock edges. The bench drives every input at the falling edge and holds each command for exactly one cycle. It pulses each acknowledge for one cycle, raised only on the line and core under test. With these inputs, the one-core-per-line, input-low, enable and mask properties can be checked on every cycle, not only at the points the scoreboard samples.

// File: rtl/irq_distributor_pkg.sv
package irq_distributor_pkg;

  localparam logic [2:0] OP_ENABLE = 3'd1;
  localparam logic [2:0] OP_DEST   = 3'd2;
  localparam logic [2:0] OP_MODE   = 3'd3;
  localparam logic [2:0] OP_MASK   = 3'd4;

  localparam logic [1:0] DISTR_BALANCED = 2'b00;

  typedef struct packed {
    logic enableSet;
    logic destWr;
    logic modeWr;
    logic maskWr;
  } strobe_t;

endpackage

// File: rtl/irq_distributor_ctrl.sv
module irq_distributor_ctrl
  import irq_distributor_pkg::*;
#(
  parameter int NUM_IRQ   = 4,
  parameter int IRQ_IDX_W = 2
) (
  input  logic                 cmdValid,
  input  logic [2:0]           cmdOp,
  input  logic [IRQ_IDX_W-1:0] cmdIrq,
  output strobe_t              strobes,
  output logic [NUM_IRQ-1:0]   lineSel
);

  always_comb begin
    strobes = '0;
    if (cmdValid) begin
      case (cmdOp)
        OP_ENABLE: strobes.enableSet = 1'b1;
        OP_DEST:   strobes.destWr    = 1'b1;
        OP_MODE:   strobes.modeWr    = 1'b1;
        OP_MASK:   strobes.maskWr    = 1'b1;
        default:   strobes = '0;
      endcase
    end
  end

  // one-hot line decode; out-of-range line numbers select nothing
  always_comb begin
    lineSel = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cmdIrq == IRQ_IDX_W'(i)) lineSel[i] = 1'b1;
    end
  end

endmodule

// File: rtl/irq_distributor_line.sv
module irq_distributor_line
  import irq_distributor_pkg::*;
#(
  parameter int NUM_CORE = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                globalEn,
  input  logic                destWr,
  input  logic                modeWr,
  input  logic                maskWr,
  input  logic [NUM_CORE-1:0] destData,
  input  logic [1:0]          distrData,
  input  logic                maskData,
  input  logic                levelIn,
  input  logic [NUM_CORE-1:0] ackIn,
  output logic [NUM_CORE-1:0] lineOut
);

  function automatic logic [NUM_CORE-1:0] lowestSet(input logic [NUM_CORE-1:0] m);
    logic [NUM_CORE-1:0] r;
    r = '0;
    for (int k = NUM_CORE - 1; k >= 0; k--) begin
      if (m[k]) begin
        r    = '0;
        r[k] = 1'b1;
      end
    end
    return r;
  endfunction

  // next set bit strictly above the current one-hot position, wrapping
  function automatic logic [NUM_CORE-1:0] nextSet(input logic [NUM_CORE-1:0] m,
                                                  input logic [NUM_CORE-1:0] cur);
    logic [NUM_CORE-1:0] r;
    int   curIdx;
    int   idx;
    logic found;
    r      = '0;
    found  = 1'b0;
    curIdx = NUM_CORE - 1;
    for (int k = 0; k < NUM_CORE; k++) begin
      if (cur[k]) curIdx = k;
    end
    for (int s = 1; s <= NUM_CORE; s++) begin
      idx = curIdx + s;
      if (idx >= NUM_CORE) idx = idx - NUM_CORE;
      if (!found && m[idx]) begin
        r[idx] = 1'b1;
        found  = 1'b1;
      end
    end
    return r;
  endfunction

  logic [NUM_CORE-1:0] destQ;
  logic [NUM_CORE-1:0] ptrQ;
  logic [1:0]          distrQ;
  logic                maskedQ;
  logic                servedQ;
  logic                prevInQ;
  logic [NUM_CORE-1:0] lineOutQ;

  logic                balanced;
  logic                live;
  logic [NUM_CORE-1:0] chosen;
  logic                ackAdv;
  logic                fallAdv;

  always_comb begin
    balanced = (distrQ == DISTR_BALANCED);
    live     = globalEn & ~maskedQ;
    chosen   = balanced ? ptrQ : lowestSet(destQ);
    ackAdv   = balanced & live & levelIn & ~servedQ & (|(ackIn & chosen));
    fallAdv  = balanced & live & ~levelIn & prevInQ & ~servedQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      destQ    <= '0;
      ptrQ     <= '0;
      distrQ   <= DISTR_BALANCED;
      maskedQ  <= 1'b1;
      servedQ  <= 1'b0;
      prevInQ  <= 1'b0;
      lineOutQ <= '0;
    end else begin
      if (destWr) begin
        destQ <= destData;
        ptrQ  <= lowestSet(destData);
      end else if (ackAdv || fallAdv) begin
        ptrQ <= nextSet(destQ, ptrQ);
      end
      if (modeWr) distrQ  <= distrData;
      if (maskWr) maskedQ <= maskData;
      servedQ  <= levelIn ? (servedQ | ackAdv) : 1'b0;
      prevInQ  <= levelIn;
      lineOutQ <= (levelIn && live) ? chosen : '0;
    end
  end

  assign lineOut = lineOutQ;

endmodule

// File: rtl/irq_distributor_datapath.sv
module irq_distributor_datapath
  import irq_distributor_pkg::*;
#(
  parameter int NUM_IRQ  = 4,
  parameter int NUM_CORE = 4,
  parameter int DATA_W   = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strobes,
  input  logic [NUM_IRQ-1:0]           lineSel,
  input  logic [DATA_W-1:0]            cmdData,
  input  logic [NUM_IRQ-1:0]           irqIn,
  input  logic [NUM_CORE*NUM_IRQ-1:0]  coreAck,
  output logic [NUM_CORE*NUM_IRQ-1:0]  irqOut
);

  logic globalEnQ;
  logic unusedDataBits;

  assign unusedDataBits = ^cmdData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  globalEnQ <= 1'b0;
    else if (strobes.enableSet) globalEnQ <= 1'b1;
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    logic [NUM_CORE-1:0] ackLine;
    logic [NUM_CORE-1:0] outLine;

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
      assign ackLine[c]             = coreAck[c*NUM_IRQ + i];
      assign irqOut[c*NUM_IRQ + i]  = outLine[c];
    end

    irq_distributor_line #(
      .NUM_CORE(NUM_CORE)
    ) line_i (
      .clk      (clk),
      .rstN     (rstN),
      .globalEn (globalEnQ),
      .destWr   (strobes.destWr & lineSel[i]),
      .modeWr   (strobes.modeWr & lineSel[i]),
      .maskWr   (strobes.maskWr & lineSel[i]),
      .destData (cmdData[NUM_CORE-1:0]),
      .distrData(cmdData[1:0]),
      .maskData (cmdData[0]),
      .levelIn  (irqIn[i]),
      .ackIn    (ackLine),
      .lineOut  (outLine)
    );
  end

endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irq_distributor_pkg::*;
#(
  parameter int NUM_IRQ   = 4,
  parameter int NUM_CORE  = 4,
  parameter int DATA_W    = 32,
  parameter int IRQ_IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cmdValid,
  input  logic [2:0]                   cmdOp,
  input  logic [IRQ_IDX_W-1:0]         cmdIrq,
  input  logic [DATA_W-1:0]            cmdData,
  input  logic [NUM_IRQ-1:0]           irqIn,
  input  logic [NUM_CORE*NUM_IRQ-1:0]  coreAck,
  output logic [NUM_CORE*NUM_IRQ-1:0]  irqOut
);

  strobe_t            strobes;
  logic [NUM_IRQ-1:0] lineSel;

  irq_distributor_ctrl #(
    .NUM_IRQ  (NUM_IRQ),
    .IRQ_IDX_W(IRQ_IDX_W)
  ) ctrl_i (
    .cmdValid(cmdValid),
    .cmdOp   (cmdOp),
    .cmdIrq  (cmdIrq),
    .strobes (strobes),
    .lineSel (lineSel)
  );

  irq_distributor_datapath #(
    .NUM_IRQ (NUM_IRQ),
    .NUM_CORE(NUM_CORE),
    .DATA_W  (DATA_W)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .lineSel(lineSel),
    .cmdData(cmdData),
    .irqIn  (irqIn),
    .coreAck(coreAck),
    .irqOut (irqOut)
  );

endmodule

// File: rtl/irq_distributor_chk.sv
module irq_distributor_chk
  import irq_distributor_pkg::*;
#(
  parameter int NUM_IRQ   = 4,
  parameter int NUM_CORE  = 4,
  parameter int DATA_W    = 32,
  parameter int IRQ_IDX_W = 2
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         cmdValid,
  input logic [2:0]                   cmdOp,
  input logic [IRQ_IDX_W-1:0]         cmdIrq,
  input logic [DATA_W-1:0]            cmdData,
  input logic [NUM_IRQ-1:0]           irqIn,
  input logic [NUM_CORE*NUM_IRQ-1:0]  irqOut
);

  logic enSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 enSeen <= 1'b0;
    else if (cmdValid && cmdOp == OP_ENABLE)   enSeen <= 1'b1;
  end

  // R2: nothing leaves the block before the enable command
  assert_quiet_before_enable_R2: assert property (
    @(posedge clk) disable iff (!rstN) !enSeen |-> irqOut == '0);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_chk
    logic [NUM_CORE-1:0] lineOut;
    logic                maskSet;

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_bit
      assign lineOut[c] = irqOut[c*NUM_IRQ + i];
    end

    assign maskSet = cmdValid && cmdOp == OP_MASK && cmdData[0] &&
                     cmdIrq == IRQ_IDX_W'(i);

    assert_one_core_per_line_R4: assert property (
      @(posedge clk) disable iff (!rstN) $onehot0(lineOut));

    assert_low_input_silent_R11: assert property (
      @(posedge clk) disable iff (!rstN) !irqIn[i] |=> lineOut == '0);

    assert_mask_blocks_R3: assert property (
      @(posedge clk) disable iff (!rstN) maskSet |-> ##2 lineOut == '0);
  end

endmodule

bind irq_distributor irq_distributor_chk #(
  .NUM_IRQ  (NUM_IRQ),
  .NUM_CORE (NUM_CORE),
  .DATA_W   (DATA_W),
  .IRQ_IDX_W(IRQ_IDX_W)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .cmdValid(cmdValid),
  .cmdOp   (cmdOp),
  .cmdIrq  (cmdIrq),
  .cmdData (cmdData),
  .irqIn   (irqIn),
  .irqOut  (irqOut)
);

// File: tb/irq_distributor_tb_top.sv
`timescale 1ns/1ps
module irq_distributor_tb_top;

  localparam int NI    = 4;
  localparam int NC    = 4;
  localparam int OUT_W = NI * NC;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cmdValid = 1'b0;
  logic [2:0]       cmdOp = '0;
  logic [1:0]       cmdIrq = '0;
  logic [31:0]      cmdData = '0;
  logic [NI-1:0]    irqIn = '0;
  logic [OUT_W-1:0] coreAck = '0;
  logic [OUT_W-1:0] irqOut;

  int totalChecks = 0;
  int failChecks  = 0;
  bit finished    = 1'b0;

  logic [OUT_W-1:0] expQ[$];
  string            tagQ[$];

  always #2.5 clk = ~clk;

  irq_distributor #(.NUM_IRQ(NI), .NUM_CORE(NC), .DATA_W(32)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdIrq(cmdIrq), .cmdData(cmdData), .irqIn(irqIn),
    .coreAck(coreAck), .irqOut(irqOut)
  );

  function automatic logic [OUT_W-1:0] bitOf(input int core, input int line);
    return OUT_W'(1) << (core * NI + line);
  endfunction

  task automatic writeCmd(input logic [2:0] op, input int line, input logic [31:0] data);
    cmdValid = 1'b1;
    cmdOp    = op;
    cmdIrq   = 2'(line);
    cmdData  = data;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic pulseAck(input int core, input int line);
    coreAck[core*NI + line] = 1'b1;
    @(negedge clk);
    coreAck = '0;
  endtask

  // driver side of the scoreboard: expected value for the next edge
  task automatic expectOut(input logic [OUT_W-1:0] exp, input string tag);
    @(posedge clk);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
  endtask

  // monitor side: compare away from the active edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [OUT_W-1:0] e;
      string            t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      totalChecks++;
      if (irqOut !== e) begin
        failChecks++;
        $display("FAIL %s: irqOut=%h expected=%h", t, irqOut, e);
      end
    end
  end

  initial begin
    logic [OUT_W-1:0] base0;
    irqIn = 4'b0001;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expectOut('0, "R1 reset state");

    writeCmd(3'd4, 0, 32'h0);
    writeCmd(3'd2, 0, 32'h2);
    writeCmd(3'd3, 0, 32'h2);
    expectOut('0, "R2 before enable");
    writeCmd(3'd1, 0, 32'h0);
    expectOut(bitOf(1, 0), "R2 after enable");

    writeCmd(3'd2, 0, 32'hC);
    expectOut(bitOf(2, 0), "R5 lowest set core");
    writeCmd(3'd3, 0, 32'hFFFF_FFF1);
    expectOut(bitOf(2, 0), "R10 upper mode bits ignored");
    writeCmd(3'd4, 0, 32'h1);
    expectOut('0, "R3 masked");
    writeCmd(3'd4, 0, 32'h0);
    expectOut(bitOf(2, 0), "R3 unmasked");
    pulseAck(2, 0);
    expectOut(bitOf(2, 0), "R12 ack in fixed routing");
    irqIn[0] = 1'b0;
    expectOut('0, "R11 follows low level");
    irqIn[0] = 1'b1;
    expectOut(bitOf(2, 0), "R11 follows high level");
    base0 = bitOf(2, 0);

    writeCmd(3'd4, 1, 32'h0);
    writeCmd(3'd2, 1, 32'hB);
    writeCmd(3'd3, 1, 32'h0);
    irqIn[1] = 1'b1;
    expectOut(base0 | bitOf(0, 1), "R6 starts at lowest core");
    pulseAck(1, 1);
    expectOut(base0 | bitOf(0, 1), "R12 non-chosen ack");
    pulseAck(0, 1);
    expectOut(base0 | bitOf(1, 1), "R6 advance on ack");
    pulseAck(1, 1);
    expectOut(base0 | bitOf(1, 1), "R7 second ack ignored");
    irqIn[1] = 1'b0;
    expectOut(base0, "R11 line low");
    irqIn[1] = 1'b1;
    expectOut(base0 | bitOf(1, 1), "R7 no extra move on deassert");
    irqIn[1] = 1'b0;
    expectOut(base0, "R11 line low again");
    irqIn[1] = 1'b1;
    expectOut(base0 | bitOf(3, 1), "R7 move on deassert");
    irqIn[1] = 1'b0;
    expectOut(base0, "R11 line low third");
    irqIn[1] = 1'b1;
    expectOut(base0 | bitOf(0, 1), "R6 wrap to lowest");

    pulseAck(0, 1);
    expectOut(base0 | bitOf(1, 1), "R6 advance before rewrite");
    writeCmd(3'd2, 1, 32'hB);
    expectOut(base0 | bitOf(0, 1), "R8 rewrite restarts choice");
    writeCmd(3'd2, 1, 32'h4);
    expectOut(base0 | bitOf(2, 1), "R8 new mask lowest bit");
    writeCmd(3'd2, 1, 32'h0);
    expectOut(base0, "R9 empty destination");
    writeCmd(3'd3, 1, 32'h2);
    writeCmd(3'd2, 1, 32'hF);
    expectOut(base0 | bitOf(0, 1), "R4 single core for full mask");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      totalChecks++;
      failChecks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
      $finish;
    end
  end

endmodule